// File: doc/BRIEF.md
# Per-Frequency Correlator Cross-Multiply Engine

This block is the cross-multiply-accumulate stage of a frequency-domain correlator, and it serves one frequency channel. Each input vector carries one complex sample for every antenna, with two polarizations per antenna. The engine forms the conjugate product of every antenna pair, self-pairs included. Each pair gives four polarization products. A register input sets how many spectra are summed. When the last spectrum of an integration has been processed, the block streams out the summed pair products.

There is one array of four complex multipliers. It walks through the pairs, one pair per clock. A new input vector can be taken every NB = N(N+1)/2 clocks, which keeps the multipliers busy on every cycle. The accumulators are not read out in a separate phase. The final spectrum of an integration drives each pair's total straight to the output, so a dump adds no dead cycles and needs no second buffer.

Framing uses a sync pulse that is high for one clock before the first valid item of a stream. On the input side it starts a new integration. On the output side it marks the start of each dump.

Top module: `xcorr_engine`

## Requirements
- R1: Each dump emits NB = N(N+1)/2 results on consecutive cycles. `out_bl` counts up from 0, and index k is the k-th pair (a,b) with a <= b, ordered by a and then by b, both ascending.
- R2: Antenna a, polarization q (0 = x, 1 = y) is read from `in_data` at element 2a+q, which is 2*DW bits wide with the real part in the low half. Product field p = 2*pa+pb (xx, xy, yx, yy) is written to `out_data` as lane 2p (real) and lane 2p+1 (imaginary), each lane AW bits wide. For samples A of antenna a and B of antenna b, the real part is Ar*Br + Ai*Bi and the imaginary part is Ai*Br - Ar*Bi.
- R3: Each output is the sum of the products of the spectra in one integration of L accepted vectors. A dump follows the L-th vector of the integration. With full-scale inputs and L = MAX_ACC the sums do not overflow.
- R4: L is the value of `acc_len` at each acceptance. A value of 0 acts as 1, and a value above MAX_ACC acts as MAX_ACC.
- R5: A pulse on `in_sync` makes the next accepted vector the first of a new integration. Partial sums from before the pulse are discarded.
- R6: `out_sync` is high for exactly the one cycle before result 0 of each dump. Result 0 appears two clocks after the accepting edge of the final vector.
- R7: Vectors presented every NB cycles are all accepted. A vector presented while the previous one still has more than one pair to process is dropped and has no effect on any sum.
- R8: While reset is held, and after it is released, `out_valid` and `out_sync` are low and the integration count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_len | input | LENW | Spectra per integration |
| in_sync | input | 1 | High one cycle before the first vector of an integration |
| in_valid | input | 1 | Input vector present |
| in_data | input | N*4*DW | Dual-polarization complex samples of all antennas |
| out_sync | output | 1 | High one cycle before result 0 of a dump |
| out_valid | output | 1 | Result present |
| out_bl | output | BLW | Pair index of the current result |
| out_data | output | 8*AW | Four complex accumulated products |

## Verification
- **Random samples.** Random vectors with single-spectrum integrations separate errors in the product formula, in the pair order and in the field layout. Every lane differs, so a swapped operand or a missing conjugate shows up at once.
- **Multi-spectrum integrations.** These expose accumulators that are not restarted between integrations. The same vectors are run with a zero length and with an over-long length to probe the clamping.
- **Sync in mid-integration.** A sync pulse in the middle of an integration shows whether stale partial sums leak into the next dump.
- **Early vector.** A vector presented one cycle early shows whether the drop rule holds.
- **Full-scale run.** Full-scale samples summed over the maximum length show whether the accumulator width is sufficient.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;
   // products per antenna pair: xx, xy, yx, yy
   localparam int NPROD = 4;

   function automatic int pair_count(input int n);
      return n * (n + 1) / 2;
   endfunction

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/xcorr_seq.sv
// Walks the antenna pairs (a <= b), one per clock, after each start.
module xcorr_seq #(
   parameter int N = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic wrap,
   output logic [xcorr_pkg::idx_width(xcorr_pkg::pair_count(N))-1:0] idx,
   output logic [xcorr_pkg::idx_width(N)-1:0] ant_a,
   output logic [xcorr_pkg::idx_width(N)-1:0] ant_b
);
   localparam int NB   = xcorr_pkg::pair_count(N);
   localparam int BLW  = xcorr_pkg::idx_width(NB);
   localparam int ANW  = xcorr_pkg::idx_width(N);
   localparam logic [ANW-1:0] LAST_ANT = ANW'(N - 1);
   localparam logic [BLW-1:0] LAST_BL  = BLW'(NB - 1);

   assign wrap = busy && (idx == LAST_BL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx   <= '0;
         ant_a <= '0;
         ant_b <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         idx   <= '0;
         ant_a <= '0;
         ant_b <= '0;
      end else if (busy) begin
         if (wrap) begin
            busy <= 1'b0;
         end else begin
            idx <= idx + 1'b1;
            if (ant_b == LAST_ANT) begin
               ant_a <= ant_a + 1'b1;
               ant_b <= ant_a + 1'b1;
            end else begin
               ant_b <= ant_b + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/xcorr_cmac.sv
// Four registered conjugate complex products for one antenna pair.
module xcorr_cmac #(
   parameter int DW = 8,
   parameter int PW = 2 * DW + 1
) (
   input  logic                              clk,
   input  logic [4*DW-1:0]                   a_vec,
   input  logic [4*DW-1:0]                   b_vec,
   output logic [xcorr_pkg::NPROD*2*PW-1:0]  prod
);
   for (genvar p = 0; p < xcorr_pkg::NPROD; p++) begin : g_prod
      localparam int PA = p / 2;
      localparam int PB = p % 2;
      logic signed [DW-1:0] ar, ai, br, bi;
      logic signed [PW-1:0] arx, aix, brx, bix;
      logic signed [PW-1:0] re_q, im_q;

      assign ar  = a_vec[PA*2*DW +: DW];
      assign ai  = a_vec[PA*2*DW+DW +: DW];
      assign br  = b_vec[PB*2*DW +: DW];
      assign bi  = b_vec[PB*2*DW+DW +: DW];
      assign arx = PW'(ar);
      assign aix = PW'(ai);
      assign brx = PW'(br);
      assign bix = PW'(bi);

      always_ff @(posedge clk) begin
         re_q <= arx * brx + aix * bix;
         im_q <= aix * brx - arx * bix;
      end

      assign prod[(2*p)*PW +: PW]   = re_q;
      assign prod[(2*p+1)*PW +: PW] = im_q;
   end
endmodule

// File: rtl/xcorr_accbank.sv
// One accumulator set per pair; the final spectrum of an integration drives totals out.
module xcorr_accbank #(
   parameter int NB  = 10,
   parameter int BLW = 4,
   parameter int PW  = 17,
   parameter int AW  = 27
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                in_valid,
   input  logic [BLW-1:0]                      in_idx,
   input  logic                                in_first,
   input  logic                                in_last,
   input  logic [xcorr_pkg::NPROD*2*PW-1:0]    in_prod,
   output logic                                out_valid,
   output logic [BLW-1:0]                      out_idx,
   output logic [xcorr_pkg::NPROD*2*AW-1:0]    out_data
);
   localparam int NL = 2 * xcorr_pkg::NPROD;

   logic signed [AW-1:0] acc_q [NB][NL];
   logic signed [AW-1:0] sum_c [NL];
   logic signed [AW-1:0] out_q [NL];

   always_comb begin
      for (int j = 0; j < NL; j++) begin
         sum_c[j] = (in_first ? '0 : acc_q[in_idx][j])
                  + AW'($signed(in_prod[j*PW +: PW]));
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         for (int j = 0; j < NL; j++) begin
            acc_q[in_idx][j] <= sum_c[j];
            out_q[j]         <= sum_c[j];
         end
         out_idx <= in_idx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid && in_last;
   end

   for (genvar j = 0; j < NL; j++) begin : g_out
      assign out_data[j*AW +: AW] = out_q[j];
   end
endmodule

// File: rtl/xcorr_engine.sv
module xcorr_engine #(
   parameter int N       = 4,
   parameter int DW      = 8,
   parameter int MAX_ACC = 1024,
   localparam int NB   = xcorr_pkg::pair_count(N),
   localparam int BLW  = xcorr_pkg::idx_width(NB),
   localparam int LENW = $clog2(MAX_ACC + 1),
   localparam int PW   = 2 * DW + 1,
   localparam int AW   = PW + $clog2(MAX_ACC),
   localparam int VW   = N * 4 * DW,
   localparam int OW   = xcorr_pkg::NPROD * 2 * AW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [LENW-1:0] acc_len,
   input  logic            in_sync,
   input  logic            in_valid,
   input  logic [VW-1:0]   in_data,
   output logic            out_sync,
   output logic            out_valid,
   output logic [BLW-1:0]  out_bl,
   output logic [OW-1:0]   out_data
);
   localparam int ANW = xcorr_pkg::idx_width(N);
   localparam logic [LENW-1:0] MAX_L = LENW'(MAX_ACC);

   if (N < 1) begin : g_bad_n
      $error("xcorr_engine: N must be at least 1");
   end
   if (DW < 2) begin : g_bad_dw
      $error("xcorr_engine: DW must be at least 2");
   end
   if (MAX_ACC < 1) begin : g_bad_acc
      $error("xcorr_engine: MAX_ACC must be at least 1");
   end

   logic            busy, wrap, accept;
   logic [BLW-1:0]  idx;
   logic [ANW-1:0]  ant_a, ant_b;
   logic [VW-1:0]   hold_q;
   logic [LENW-1:0] spec_cnt;
   logic [LENW:0]   eff_len;
   logic            first_now, last_now, first_q, last_q;
   logic            pv_q, pfirst_q, plast_q, osync_q;
   logic [BLW-1:0]  pidx_q;
   logic [4*DW-1:0] a_vec, b_vec;
   logic [xcorr_pkg::NPROD*2*PW-1:0] prod;

   // a new vector may enter on the last pair of the previous one
   assign accept = in_valid && (!busy || wrap);

   always_comb begin
      if (acc_len == '0)        eff_len = (LENW+1)'(1);
      else if (acc_len > MAX_L) eff_len = {1'b0, MAX_L};
      else                      eff_len = {1'b0, acc_len};
   end
   assign first_now = (spec_cnt == '0);
   assign last_now  = (({1'b0, spec_cnt} + (LENW+1)'(1)) >= eff_len);

   xcorr_seq #(.N(N)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .wrap(wrap),
      .idx(idx), .ant_a(ant_a), .ant_b(ant_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spec_cnt <= '0;
         first_q  <= 1'b0;
         last_q   <= 1'b0;
         pv_q     <= 1'b0;
         pidx_q   <= '0;
         pfirst_q <= 1'b0;
         plast_q  <= 1'b0;
         osync_q  <= 1'b0;
      end else begin
         if (accept) begin
            first_q  <= first_now;
            last_q   <= last_now;
            spec_cnt <= last_now ? '0 : spec_cnt + 1'b1;
         end
         if (in_sync) spec_cnt <= '0;
         pv_q     <= busy;
         pidx_q   <= idx;
         pfirst_q <= first_q;
         plast_q  <= last_q;
         osync_q  <= busy && (idx == '0) && last_q;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) hold_q <= in_data;
   end

   assign a_vec = hold_q[ant_a*4*DW +: 4*DW];
   assign b_vec = hold_q[ant_b*4*DW +: 4*DW];

   xcorr_cmac #(.DW(DW), .PW(PW)) u_cmac (
      .clk(clk), .a_vec(a_vec), .b_vec(b_vec), .prod(prod)
   );

   xcorr_accbank #(.NB(NB), .BLW(BLW), .PW(PW), .AW(AW)) u_acc (
      .clk(clk), .rst_n(rst_n), .in_valid(pv_q), .in_idx(pidx_q),
      .in_first(pfirst_q), .in_last(plast_q), .in_prod(prod),
      .out_valid(out_valid), .out_idx(out_bl), .out_data(out_data)
   );

   assign out_sync = osync_q;
endmodule

// File: rtl/xcorr_chk.sv
module xcorr_chk #(
   parameter int N   = 4,
   parameter int AW  = 27,
   parameter int BLW = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                out_sync,
   input logic                out_valid,
   input logic [BLW-1:0]      out_bl,
   input logic [8*AW-1:0]     out_data
);
   localparam int NB = xcorr_pkg::pair_count(N);

   function automatic logic is_auto(input logic [BLW-1:0] k);
      int n = 0;
      logic r = 1'b0;
      for (int a = 0; a < N; a++) begin
         for (int b = a; b < N; b++) begin
            if (n == int'(k)) r = (a == b);
            n++;
         end
      end
      return r;
   endfunction

   logic signed [AW-1:0] ln [8];
   for (genvar j = 0; j < 8; j++) begin : g_ln
      assign ln[j] = out_data[j*AW +: AW];
   end

   p_reset_quiet_r8: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && !out_sync));

   p_sync_then_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_sync |=> (out_valid && out_bl == '0));

   p_first_has_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_bl == '0) |-> $past(out_sync));

   p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_bl != BLW'(NB - 1)) |=>
         (out_valid && out_bl == $past(out_bl) + 1'b1));

   p_bl_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_bl <= BLW'(NB - 1)));

   p_auto_real_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && is_auto(out_bl)) |->
         (ln[1] == '0 && ln[7] == '0 && ln[0] >= 0 && ln[6] >= 0));

   p_auto_conj_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && is_auto(out_bl)) |-> (ln[2] == ln[4] && ln[3] == -ln[5]));
endmodule

bind xcorr_engine xcorr_chk #(.N(N), .AW(AW), .BLW(BLW)) u_chk (
   .clk(clk), .rst_n(rst_n), .out_sync(out_sync), .out_valid(out_valid),
   .out_bl(out_bl), .out_data(out_data)
);

// File: tb/xcorr_engine_tb_top.sv
module xcorr_engine_tb_top;
   localparam int N       = 4;
   localparam int DW      = 8;
   localparam int MAX_ACC = 1024;
   localparam int NB      = N * (N + 1) / 2;
   localparam int BLW     = $clog2(NB);
   localparam int LENW    = $clog2(MAX_ACC + 1);
   localparam int PW      = 2 * DW + 1;
   localparam int AW      = PW + $clog2(MAX_ACC);
   localparam int VW      = N * 4 * DW;
   localparam int OW      = 8 * AW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [LENW-1:0] acc_len = '0;
   logic            in_sync = 1'b0;
   logic            in_valid = 1'b0;
   logic [VW-1:0]   in_data = '0;
   logic            out_sync, out_valid;
   logic [BLW-1:0]  out_bl;
   logic [OW-1:0]   out_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string cur_req = "R2";

   typedef struct {
      int            bl;
      logic [OW-1:0] data;
   } exp_t;
   exp_t   sb[$];
   longint macc [NB][8];
   int     mcnt = 0;

   always #4 clk = ~clk;

   xcorr_engine #(.N(N), .DW(DW), .MAX_ACC(MAX_ACC)) dut_i (
      .clk(clk), .rst_n(rst_n), .acc_len(acc_len), .in_sync(in_sync),
      .in_valid(in_valid), .in_data(in_data), .out_sync(out_sync),
      .out_valid(out_valid), .out_bl(out_bl), .out_data(out_data)
   );

   function automatic longint smp(input logic [VW-1:0] v, input int a, input int q, input int c);
      logic signed [DW-1:0] s;
      s = v[((a*2+q)*2+c)*DW +: DW];
      return longint'(s);
   endfunction

   // reference model: R2 products, R3/R4 integration length, R1 order
   task automatic model_accept(input logic [VW-1:0] v);
      int eff, k;
      bit first, last;
      eff   = (acc_len == 0) ? 1 : ((int'(acc_len) > MAX_ACC) ? MAX_ACC : int'(acc_len));
      first = (mcnt == 0);
      last  = (mcnt + 1 >= eff);
      k = 0;
      for (int a = 0; a < N; a++) begin
         for (int b = a; b < N; b++) begin
            exp_t e;
            for (int p = 0; p < 4; p++) begin
               longint ar, ai, br, bi;
               ar = smp(v, a, p / 2, 0); ai = smp(v, a, p / 2, 1);
               br = smp(v, b, p % 2, 0); bi = smp(v, b, p % 2, 1);
               macc[k][2*p]   = (first ? 0 : macc[k][2*p])   + ar * br + ai * bi;
               macc[k][2*p+1] = (first ? 0 : macc[k][2*p+1]) + ai * br - ar * bi;
            end
            if (last) begin
               e.bl = k;
               for (int j = 0; j < 8; j++) e.data[j*AW +: AW] = macc[k][j][AW-1:0];
               sb.push_back(e);
            end
            k++;
         end
      end
      mcnt = last ? 0 : mcnt + 1;
   endtask

   function automatic logic [VW-1:0] rand_vec();
      logic [VW-1:0] v;
      for (int w = 0; w < VW / 32; w++) v[w*32 +: 32] = $urandom;
      return v;
   endfunction

   // R7: vectors are spaced exactly NB cycles apart; drop inserts one early vector
   task automatic send(input logic [VW-1:0] v, input bit with_sync, input bit with_drop);
      if (with_sync) begin
         @(negedge clk) in_sync = 1'b1;
         mcnt = 0;
      end
      @(negedge clk);
      in_sync  = 1'b0;
      in_valid = 1'b1;
      in_data  = v;
      model_accept(v);
      @(negedge clk);
      if (with_drop) begin
         in_data = rand_vec();
         @(negedge clk);
         in_valid = 1'b0;
         repeat (NB - 3) @(negedge clk);
      end else begin
         in_valid = 1'b0;
         repeat (NB - 2) @(negedge clk);
      end
   endtask

   // monitor / scoreboard
   logic prev_sync = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (out_bl == '0) begin
               checks++;
               if (!prev_sync) begin
                  errors++;
                  $display("FAIL R6 out_sync before result 0: got %0d exp 1", prev_sync);
               end
            end
            checks++;
            if (sb.size() == 0) begin
               errors++;
               $display("FAIL R1 unexpected result bl %0d: got 1 item exp 0", out_bl);
            end else begin
               exp_t e;
               e = sb.pop_front();
               if (int'(out_bl) != e.bl || out_data !== e.data) begin
                  errors++;
                  $display("FAIL %s bl got %0d exp %0d data got %h exp %h",
                           cur_req, out_bl, e.bl, out_data, e.data);
               end
            end
         end
         prev_sync = out_sync;
      end
   end

   task automatic drain(input string req);
      repeat (NB + 6) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL %s results missing: got %0d left exp 0", req, sb.size());
         sb.delete();
      end
   endtask

   initial begin
      logic [VW-1:0] fs;
      repeat (3) @(negedge clk);
      // R8: quiet during and after reset
      checks++;
      if (out_valid || out_sync) begin
         errors++;
         $display("FAIL R8 in reset: got valid %0d sync %0d exp 0 0", out_valid, out_sync);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid || out_sync) begin
         errors++;
         $display("FAIL R8 after reset: got valid %0d sync %0d exp 0 0", out_valid, out_sync);
      end

      // R1 R2 R7: single-spectrum integrations, back to back at NB spacing
      cur_req = "R2";
      acc_len = LENW'(1);
      for (int i = 0; i < 4; i++) send(rand_vec(), 1'b0, 1'b0);
      drain("R1");

      // R3: three-spectrum integrations
      cur_req = "R3";
      acc_len = LENW'(3);
      for (int i = 0; i < 6; i++) send(rand_vec(), 1'b0, 1'b0);
      drain("R3");

      // R4: zero length acts as one
      cur_req = "R4";
      acc_len = '0;
      for (int i = 0; i < 3; i++) send(rand_vec(), 1'b0, 1'b0);
      drain("R4");

      // R7: early vector is dropped
      cur_req = "R7";
      acc_len = LENW'(2);
      for (int i = 0; i < 4; i++) send(rand_vec(), 1'b0, (i % 2) == 0);
      drain("R7");

      // R5: sync in mid-integration discards partial sums
      cur_req = "R5";
      acc_len = LENW'(4);
      send(rand_vec(), 1'b0, 1'b0);
      send(rand_vec(), 1'b0, 1'b0);
      send(rand_vec(), 1'b1, 1'b0);
      for (int i = 0; i < 3; i++) send(rand_vec(), 1'b0, 1'b0);
      drain("R5");

      // R3 R4: full-scale inputs, over-long length clamps to MAX_ACC
      cur_req = "R3";
      acc_len = '1;
      for (int a = 0; a < N; a++) begin
         fs[(a*4+0)*DW +: DW] = 8'h80;
         fs[(a*4+1)*DW +: DW] = (a % 2) ? 8'h7F : 8'h80;
         fs[(a*4+2)*DW +: DW] = 8'h80;
         fs[(a*4+3)*DW +: DW] = 8'h80;
      end
      for (int i = 0; i < MAX_ACC; i++) send(fs, i == 0, 1'b0);
      drain("R3");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule